// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular table of two-word transmit descriptors kept in host memory and turns each descriptor that hardware owns into one buffer-read request for a transmit FIFO. Every descriptor has a flag word and a buffer-address word. The flag word carries the byte length, the packet start and end markers, the checksum control fields and the ownership bit. When software posts a packet, it writes a one-shot kick strobe. The engine then fetches descriptors at the current ring position until it finds one that hardware does not own.

For each owned descriptor the engine reads both words over a simple request/response memory port. It presents the buffer address and length on a valid/ready request stream. After that request is taken, it writes the flag word back with ownership returned to software and steps the ring position, wrapping at the programmed ring size. The ring position is a fixed, ring-aligned base concatenated with a displacement. The number of entries is programmable in blocks of 16 with the default widths, from 16 up to 256. The block also reports three events: a pulse per finished packet, a pulse when a packet is framed wrongly, and an "all sent" pulse. The "all sent" pulse can optionally be held back until the downstream FIFO has drained.

Top module: `txring_fetch`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, the displacement reads 0, `kick_pending` is 0 and no memory or buffer request is valid until a kick is posted.
- R2: A `kick_wr` strobe makes `kick_pending` read 1 from the next cycle on. The bit clears once the engine takes the command and begins a walk, which happens one cycle later when fetching is enabled.
- R3: While `cfg_dma_en` is 0, no flag-word fetch is issued and a posted kick stays pending. Setting the enable later starts the walk.
- R4: The flag word of the current descriptor is read at byte address {base, displacement, 3'b000} and the address word at that address plus 4. Flag bit 31 set means hardware owns the descriptor. The walk stops at the first descriptor whose bit 31 is 0, and that descriptor is not consumed.
- R5: For each owned descriptor, one buffer request is made. Its address is the second word, its length is flag bits 13:0 and `buf_last` is flag bit 29 (end of packet). The request is held stable until `buf_ready`.
- R6: After the buffer request is accepted, the flag word is written back to its own address with bit 31 cleared and bits 30:0 unchanged. Bits 28:14 are the checksum enable, stuff and start fields.
- R7: Each write-back that is accepted advances the displacement by one. After entry (cfg_ring_size+1)*16-1 the displacement wraps to 0.
- R8: `pkt_done` pulses once for each written-back descriptor that has flag bit 29 set.
- R9: `eop_err` pulses when a descriptor with start-of-packet (flag bit 30) arrives while a packet is still open. It also pulses when the walk stops while a packet is open. A packet is open after a descriptor without bit 29, until a descriptor with bit 29.
- R10: With `cfg_drain_wait` at 0, `all_sent` pulses once when a walk that consumed at least one descriptor stops. A walk that consumed none raises no pulse.
- R11: With `cfg_drain_wait` at 1, that `all_sent` pulse is withheld until `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dma_en | input | 1 | Enables descriptor fetching |
| cfg_drain_wait | input | 1 | 1: the all-sent pulse waits for an empty FIFO |
| cfg_ring_base | input | BASE_W | Ring base, upper address bits |
| cfg_ring_size | input | SIZE_W | Ring entries = (value+1)*16 with the defaults |
| kick_wr | input | 1 | One-cycle transmit-pending command strobe |
| kick_pending | output | 1 | Command posted and not yet taken |
| cur_disp | output | DISP_W | Current ring displacement |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write-back, 0 for read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid, at least one cycle after the read is accepted |
| mem_rsp_data | input | 32 | Read data |
| buf_valid | output | 1 | Buffer read request valid |
| buf_ready | input | 1 | Buffer read request accepted |
| buf_addr | output | 32 | Buffer start address |
| buf_len | output | 14 | Buffer length in bytes |
| buf_last | output | 1 | Buffer ends a packet |
| fifo_empty | input | 1 | Downstream transmit FIFO is empty |
| pkt_done | output | 1 | Pulse per finished end-of-packet descriptor |
| eop_err | output | 1 | Pulse on a packet framing error |
| all_sent | output | 1 | Pulse when a walk has finished |

## Verification
The bench builds the block with its default widths: a 21-bit base, an 8-bit displacement and a 4-bit size field. At these widths a full sweep of every ring entry costs only a few thousand cycles. The sweep covers ring sizes of 16, 32, 80 and 256 entries and fills each ring completely, so every walk crosses the wrap point and ends where it started. Small 16-entry rings are used to place walks across the wrap and to build the framing-error, gating and drain cases. Random stalls on both ready inputs exercise the hold behaviour of each request.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned LEN_W     = 14;
   localparam int unsigned DESC_LOG2 = 3;   // two 32-bit words per descriptor
   localparam int unsigned OWN_POS   = 31;

   // flag word, most significant field first
   typedef struct packed {
      logic        own;       // 31: 1 = hardware holds it
      logic        sop;       // 30
      logic        eop;       // 29
      logic        ck_en;     // 28
      logic [7:0]  ck_stuff;  // 27:20
      logic [5:0]  ck_start;  // 19:14
      logic [13:0] len;       // 13:0
   } desc_flags_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FREQ,
      ST_FRSP,
      ST_AREQ,
      ST_ARSP,
      ST_BUF,
      ST_WB,
      ST_DRAIN
   } walk_state_t;

endpackage

// File: rtl/txr_kick_reg.sv
`timescale 1ns/1ps
module txr_kick_reg (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic take_i,
   output logic pending_o
);

   always_ff @(posedge clk) begin
      if (rst)
         pending_o <= 1'b0;
      else if (set_i)
         pending_o <= 1'b1;
      else if (take_i)
         pending_o <= 1'b0;
   end

endmodule

// File: rtl/txr_ring_ptr.sv
`timescale 1ns/1ps
module txr_ring_ptr #(
   parameter int unsigned DISP_W = 8,
   parameter int unsigned SIZE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [DISP_W-1:0] disp_o
);

   localparam int unsigned STEP_W = DISP_W - SIZE_W;

   logic [DISP_W-1:0] last_idx;

   generate
      if (STEP_W == 0) begin : g_unit_step
         assign last_idx = size_i;
      end else begin : g_block_step
         assign last_idx = {size_i, {STEP_W{1'b1}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         disp_o <= '0;
      else if (adv_i)
         disp_o <= (disp_o == last_idx) ? '0 : disp_o + DISP_W'(1);
   end

   // R7: the displacement only ever steps by one or returns to zero
   assert_disp_step_R7: assert property (@(posedge clk) disable iff (rst)
      (disp_o != $past(disp_o)) |-> ((disp_o - $past(disp_o)) == DISP_W'(1) || disp_o == '0));

endmodule

// File: rtl/txr_frame_chk.sv
`timescale 1ns/1ps
module txr_frame_chk (
   input  logic clk,
   input  logic rst,
   input  logic seen_i,
   input  logic sop_i,
   input  logic eop_i,
   input  logic stop_i,
   output logic err_o
);

   logic open_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         err_o <= 1'b0;
         if (seen_i) begin
            if (sop_i && open_q)
               err_o <= 1'b1;
            open_q <= !eop_i;
         end else if (stop_i) begin
            if (open_q)
               err_o <= 1'b1;
            open_q <= 1'b0;
         end
      end
   end

   // R9: an error pulse always follows a descriptor arrival or a walk stop
   assert_err_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
      err_o |-> $past(seen_i || stop_i));

endmodule

// File: rtl/txring_fetch.sv
`timescale 1ns/1ps
module txring_fetch
   import txr_pkg::*;
#(
   parameter int unsigned BASE_W = 21,
   parameter int unsigned DISP_W = 8,
   parameter int unsigned SIZE_W = 4,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_dma_en,
   input  logic              cfg_drain_wait,
   input  logic [BASE_W-1:0] cfg_ring_base,
   input  logic [SIZE_W-1:0] cfg_ring_size,
   input  logic              kick_wr,
   output logic              kick_pending,
   output logic [DISP_W-1:0] cur_disp,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [WORD_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data,
   output logic              buf_valid,
   input  logic              buf_ready,
   output logic [WORD_W-1:0] buf_addr,
   output logic [LEN_W-1:0]  buf_len,
   output logic              buf_last,
   input  logic              fifo_empty,
   output logic              pkt_done,
   output logic              eop_err,
   output logic              all_sent
);

   localparam int unsigned WORD_BYTES = WORD_W / 8;

   generate
      if (ADDR_W != BASE_W + DISP_W + DESC_LOG2) begin : g_bad_addr
         $error("ADDR_W must equal BASE_W + DISP_W + 3");
      end
      if (SIZE_W < 1 || SIZE_W > DISP_W) begin : g_bad_size
         $error("SIZE_W must lie between 1 and DISP_W");
      end
   endgenerate

   walk_state_t       st_q, st_d;
   desc_flags_t       flags_q, rsp_flags, wb_flags;
   logic [WORD_W-1:0] baddr_q;
   logic              moved_q;
   logic              take, rearm, adv, seen, stop, fire_all;
   logic [ADDR_W-1:0] flag_addr;

   assign rsp_flags = mem_rsp_data;
   assign flag_addr = {cfg_ring_base, cur_disp, {DESC_LOG2{1'b0}}};

   txr_kick_reg u_kick (
      .clk       (clk),
      .rst       (rst),
      .set_i     (kick_wr | rearm),
      .take_i    (take),
      .pending_o (kick_pending)
   );

   txr_ring_ptr #(
      .DISP_W (DISP_W),
      .SIZE_W (SIZE_W)
   ) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .adv_i  (adv),
      .size_i (cfg_ring_size),
      .disp_o (cur_disp)
   );

   txr_frame_chk u_frame (
      .clk    (clk),
      .rst    (rst),
      .seen_i (seen),
      .sop_i  (rsp_flags.sop),
      .eop_i  (rsp_flags.eop),
      .stop_i (stop),
      .err_o  (eop_err)
   );

   // walk sequencing
   always_comb begin
      st_d     = st_q;
      take     = 1'b0;
      rearm    = 1'b0;
      adv      = 1'b0;
      seen     = 1'b0;
      stop     = 1'b0;
      fire_all = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (kick_pending && cfg_dma_en) begin
               take = 1'b1;
               st_d = ST_FREQ;
            end
         end
         ST_FREQ: begin
            if (!cfg_dma_en) begin
               rearm = 1'b1;
               st_d  = ST_IDLE;
            end else if (mem_req_ready) begin
               st_d = ST_FRSP;
            end
         end
         ST_FRSP: begin
            if (mem_rsp_valid) begin
               if (rsp_flags.own) begin
                  seen = 1'b1;
                  st_d = ST_AREQ;
               end else begin
                  stop = 1'b1;
                  if (!moved_q) begin
                     st_d = ST_IDLE;
                  end else if (cfg_drain_wait) begin
                     st_d = ST_DRAIN;
                  end else begin
                     fire_all = 1'b1;
                     st_d     = ST_IDLE;
                  end
               end
            end
         end
         ST_AREQ: if (mem_req_ready) st_d = ST_ARSP;
         ST_ARSP: if (mem_rsp_valid) st_d = ST_BUF;
         ST_BUF:  if (buf_ready)     st_d = ST_WB;
         ST_WB: begin
            if (mem_req_ready) begin
               adv  = 1'b1;
               st_d = ST_FREQ;
            end
         end
         ST_DRAIN: begin
            if (fifo_empty) begin
               fire_all = 1'b1;
               st_d     = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         flags_q  <= '0;
         baddr_q  <= '0;
         moved_q  <= 1'b0;
         pkt_done <= 1'b0;
         all_sent <= 1'b0;
      end else begin
         st_q     <= st_d;
         pkt_done <= adv && flags_q.eop;
         all_sent <= fire_all;
         if (seen)
            flags_q <= rsp_flags;
         if (st_q == ST_ARSP && mem_rsp_valid)
            baddr_q <= mem_rsp_data;
         if (adv)
            moved_q <= 1'b1;
         else if (stop)
            moved_q <= 1'b0;
      end
   end

   // request outputs
   always_comb begin
      wb_flags     = flags_q;
      wb_flags.own = 1'b0;
   end

   assign mem_req_valid = (st_q == ST_FREQ && cfg_dma_en) || st_q == ST_AREQ || st_q == ST_WB;
   assign mem_req_write = (st_q == ST_WB);
   assign mem_req_addr  = (st_q == ST_AREQ) ? (flag_addr | ADDR_W'(WORD_BYTES)) : flag_addr;
   assign mem_req_wdata = wb_flags;
   assign buf_valid     = (st_q == ST_BUF);
   assign buf_addr      = baddr_q;
   assign buf_len       = flags_q.len;
   assign buf_last      = flags_q.eop;

   // R2: a posted command is visible on the next cycle
   assert_kick_visible_R2: assert property (@(posedge clk) disable iff (rst)
      kick_wr |=> kick_pending);

   // R3: no flag-word read goes out while fetching is disabled
   assert_fetch_gated_R3: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_write && !mem_req_addr[DESC_LOG2-1]) |-> cfg_dma_en);

   // R5: a stalled buffer request keeps its contents
   assert_buf_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len) && $stable(buf_last)));

   // R6: write-back never hands ownership back to hardware
   assert_wb_clears_own_R6: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && mem_req_write) |-> !mem_req_wdata[OWN_POS]);

   // R8: packet completion and walk completion never coincide
   assert_done_apart_R8: assert property (@(posedge clk) disable iff (rst)
      pkt_done |-> !all_sent);

endmodule

// File: tb/txring_fetch_tb_top.sv
`timescale 1ns/1ps
module txring_fetch_tb_top;
   import txr_pkg::*;

   localparam int BASE_W = 21;
   localparam int DISP_W = 8;
   localparam int SIZE_W = 4;
   localparam int ADDR_W = 32;
   localparam logic [BASE_W-1:0] RING_BASE = 21'h0ACE5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst = 1'b1;
   logic              cfg_dma_en = 1'b1;
   logic              cfg_drain_wait = 1'b0;
   logic [SIZE_W-1:0] cfg_ring_size = '0;
   logic              kick_wr = 1'b0;
   logic              kick_pending;
   logic [DISP_W-1:0] cur_disp;
   logic              mem_req_valid, mem_req_ready, mem_req_write;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [31:0]       mem_req_wdata;
   logic              mem_rsp_valid;
   logic [31:0]       mem_rsp_data;
   logic              buf_valid, buf_ready, buf_last;
   logic [31:0]       buf_addr;
   logic [13:0]       buf_len;
   logic              fifo_empty = 1'b1;
   logic              pkt_done, eop_err, all_sent;

   txring_fetch #(
      .BASE_W (BASE_W), .DISP_W (DISP_W), .SIZE_W (SIZE_W), .ADDR_W (ADDR_W)
   ) dut_i (
      .clk (clk), .rst (rst),
      .cfg_dma_en (cfg_dma_en), .cfg_drain_wait (cfg_drain_wait),
      .cfg_ring_base (RING_BASE), .cfg_ring_size (cfg_ring_size),
      .kick_wr (kick_wr), .kick_pending (kick_pending), .cur_disp (cur_disp),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write), .mem_req_addr (mem_req_addr),
      .mem_req_wdata (mem_req_wdata), .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data), .buf_valid (buf_valid), .buf_ready (buf_ready),
      .buf_addr (buf_addr), .buf_len (buf_len), .buf_last (buf_last),
      .fifo_empty (fifo_empty), .pkt_done (pkt_done), .eop_err (eop_err),
      .all_sent (all_sent)
   );

   logic [31:0] mem_w [0:511];
   logic [31:0] dsc_flags [0:255];
   logic [31:0] dsc_addr  [0:255];
   logic [15:0] lfsr = 16'hACE1;
   logic        rsp_v = 1'b0;
   logic [31:0] rsp_d = '0;

   int n_checks = 0, n_fail = 0;
   int n_buf = 0, n_pkt = 0, n_err = 0, n_all = 0, n_req = 0;
   int mon_idx = 0;
   int ring_last = 15;

   assign mem_req_ready = lfsr[2] | lfsr[5];
   assign buf_ready     = lfsr[7] | lfsr[9];
   assign mem_rsp_valid = rsp_v;
   assign mem_rsp_data  = rsp_d;

   task automatic check_eq(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model and output monitor
   always @(posedge clk) begin
      lfsr  <= rst ? 16'hACE1 : {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rsp_v <= 1'b0;
      if (!rst) begin
         if (mem_req_valid) n_req++;
         if (mem_req_valid && mem_req_ready) begin
            check_eq("R4 ring base of request", longint'(mem_req_addr[31:11]), longint'(RING_BASE));
            if (mem_req_write) begin
               check_eq("R6 write-back address", longint'(mem_req_addr[10:0]), longint'(mon_idx * 8));
               check_eq("R6 write-back data", longint'(mem_req_wdata),
                        longint'(dsc_flags[mon_idx] & 32'h7FFF_FFFF));
               mem_w[mem_req_addr[10:2]] <= mem_req_wdata;
               mon_idx = (mon_idx == ring_last) ? 0 : mon_idx + 1;
            end else begin
               rsp_v <= 1'b1;
               rsp_d <= mem_w[mem_req_addr[10:2]];
            end
         end
         if (buf_valid && buf_ready) begin
            n_buf++;
            check_eq("R5 buffer address", longint'(buf_addr), longint'(dsc_addr[mon_idx]));
            check_eq("R5 buffer length", longint'(buf_len), longint'(dsc_flags[mon_idx][13:0]));
            check_eq("R5 buffer last", longint'(buf_last), longint'(dsc_flags[mon_idx][29]));
         end
         if (pkt_done) n_pkt++;
         if (eop_err)  n_err++;
         if (all_sent) n_all++;
      end
   end

   task automatic set_desc(input int i, input bit own, input bit sop, input bit eop,
                           input int len, input logic [31:0] ba);
      logic [31:0] f;
      f = {own, sop, eop, 1'(i & 1), 8'(i * 7), 6'(i * 5), 14'(len)};
      dsc_flags[i] = f;
      dsc_addr[i]  = ba;
      mem_w[2*i]   <= f;
      mem_w[2*i+1] <= ba;
   endtask

   task automatic clear_ring();
      for (int i = 0; i < 256; i++) set_desc(i, 1'b0, 1'b0, 1'b0, 0, 32'h0);
   endtask

   task automatic zero_counts();
      n_buf = 0; n_pkt = 0; n_err = 0; n_all = 0; n_req = 0;
   endtask

   task automatic do_reset(input int sz);
      @(negedge clk);
      rst = 1'b1;
      cfg_ring_size = SIZE_W'(sz);
      ring_last = (sz + 1) * 16 - 1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      mon_idx = 0;
      clear_ring();
      zero_counts();
   endtask

   task automatic wait_quiet();
      int quiet = 0;
      int guard = 0;
      while (quiet < 8 && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (mem_req_valid || buf_valid || kick_pending) quiet = 0;
         else quiet++;
      end
   endtask

   task automatic kick_and_wait();
      @(negedge clk) kick_wr = 1'b1;
      @(negedge clk) kick_wr = 1'b0;
      wait_quiet();
   endtask

   initial begin
      int szs [4] = '{0, 1, 4, 15};

      // R1: reset state
      do_reset(0);
      check_eq("R1 displacement after reset", cur_disp, 0);
      check_eq("R1 pending after reset", kick_pending, 0);
      check_eq("R1 memory request idle", mem_req_valid, 0);
      check_eq("R1 buffer request idle", buf_valid, 0);
      check_eq("R1 pulses idle", {pkt_done, eop_err, all_sent}, 0);

      // R2 / R10: kick with an empty ring
      @(negedge clk) kick_wr = 1'b1;
      @(negedge clk) kick_wr = 1'b0;
      check_eq("R2 pending reads one", kick_pending, 1);
      @(negedge clk);
      check_eq("R2 pending self-clears", kick_pending, 0);
      wait_quiet();
      check_eq("R10 no all-sent for empty walk", n_all, 0);
      check_eq("R4 unowned descriptor not consumed", cur_disp, 0);

      // full-ring sweeps: R4 R5 R6 R7 R8 R10
      foreach (szs[k]) begin
         int n;
         int exp_pkts;
         do_reset(szs[k]);
         n = (szs[k] + 1) * 16;
         exp_pkts = 0;
         for (int i = 0; i < n; i++) begin
            bit sop;
            bit eop;
            sop = (i % 3 == 0);
            eop = (i % 3 == 2) || (i == n - 1);
            if (eop) exp_pkts++;
            set_desc(i, 1'b1, sop, eop, (i * 37 + 3) % 16384, 32'h4000_0000 + i * 32'h105);
         end
         kick_and_wait();
         check_eq("R4 descriptors consumed", n_buf, n);
         check_eq("R7 displacement wrapped to start", cur_disp, 0);
         check_eq("R8 packets completed", n_pkt, exp_pkts);
         check_eq("R9 no framing error", n_err, 0);
         check_eq("R10 one all-sent pulse", n_all, 1);
         check_eq("R6 ownership returned in memory", mem_w[2*(n-1)][31], 0);
      end

      // R7: walks placed across the wrap point of a 16-entry ring
      do_reset(0);
      for (int i = 0; i < 10; i++) set_desc(i, 1'b1, 1'b1, 1'b1, i + 1, 32'h5000_0000 + i * 64);
      kick_and_wait();
      check_eq("R7 displacement after ten", cur_disp, 10);
      check_eq("R4 ten consumed", n_buf, 10);
      zero_counts();
      for (int i = 10; i < 16; i++) set_desc(i, 1'b1, 1'b1, 1'b1, i + 100, 32'h6000_0000 + i * 16);
      for (int i = 0; i < 3; i++)   set_desc(i, 1'b1, 1'b1, 1'b1, i + 200, 32'h7000_0000 + i * 16);
      kick_and_wait();
      check_eq("R7 displacement after wrap", cur_disp, 3);
      check_eq("R4 nine consumed across wrap", n_buf, 9);
      check_eq("R8 nine packets", n_pkt, 9);
      check_eq("R10 all-sent after wrap walk", n_all, 1);

      // R3: fetching disabled
      zero_counts();
      cfg_dma_en = 1'b0;
      set_desc(3, 1'b1, 1'b1, 1'b1, 77, 32'h0000_1230);
      @(negedge clk) kick_wr = 1'b1;
      @(negedge clk) kick_wr = 1'b0;
      repeat (40) @(negedge clk);
      check_eq("R3 no request while disabled", n_req, 0);
      check_eq("R3 kick stays pending", kick_pending, 1);
      cfg_dma_en = 1'b1;
      wait_quiet();
      check_eq("R3 walk after enable", n_buf, 1);
      check_eq("R3 pending taken after enable", kick_pending, 0);
      check_eq("R7 displacement after enable walk", cur_disp, 4);

      // R9: framing errors
      do_reset(0);
      set_desc(0, 1'b1, 1'b1, 1'b0, 10, 32'h100);
      kick_and_wait();
      check_eq("R9 stop with open packet", n_err, 1);
      check_eq("R8 no packet finished", n_pkt, 0);
      check_eq("R10 all-sent after error walk", n_all, 1);
      zero_counts();
      set_desc(1, 1'b1, 1'b1, 1'b0, 11, 32'h200);
      set_desc(2, 1'b1, 1'b1, 1'b1, 12, 32'h300);
      kick_and_wait();
      check_eq("R9 start while open", n_err, 1);
      check_eq("R8 restarted packet finished", n_pkt, 1);
      zero_counts();
      set_desc(3, 1'b1, 1'b1, 1'b0, 13, 32'h400);
      set_desc(4, 1'b1, 1'b0, 1'b1, 14, 32'h500);
      kick_and_wait();
      check_eq("R9 two-part packet clean", n_err, 0);
      check_eq("R8 two-part packet once", n_pkt, 1);
      check_eq("R7 displacement after framing", cur_disp, 5);

      // R11: drain wait
      zero_counts();
      cfg_drain_wait = 1'b1;
      fifo_empty = 1'b0;
      set_desc(5, 1'b1, 1'b1, 1'b1, 15, 32'h600);
      @(negedge clk) kick_wr = 1'b1;
      @(negedge clk) kick_wr = 1'b0;
      repeat (40) @(negedge clk);
      check_eq("R11 withheld while FIFO busy", n_all, 0);
      check_eq("R11 descriptor still consumed", n_buf, 1);
      fifo_empty = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R11 fires once FIFO empty", n_all, 1);
      zero_counts();
      set_desc(6, 1'b1, 1'b1, 1'b1, 16, 32'h700);
      kick_and_wait();
      check_eq("R11 immediate when already empty", n_all, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R4 walk: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule